// File: doc/BRIEF.md
# Address remapping lookup table

This block rewrites the destination address of outgoing transactions through a table that software can write. Bits [31:20] of the incoming 32-bit address select one of 4096 table entries. That entry replaces the selected upper bits, and address bits [19:0] pass through untouched. The rest of the transaction, a payload word the block never interprets, travels alongside the address. Address, payload and valid all arrive at the output together, exactly one clock later.

A per-transaction mode input selects the result width. The narrow result is a 32-bit address built from the low 12 bits of the entry, zero-extended to the 64-bit output. The wide result is a 64-bit address built from the full 44-bit entry. Entries are loaded through a separate register-style port that writes one 32-bit word per cycle. Each entry is reached as two words.

The downstream side is assumed always ready. The block never stalls and has no flow control.

Top module: `remap_lut`

## Requirements
- R1: With mode_wide=0 during the input cycle, out_addr equals {32'b0, entry[11:0], in_addr[19:0]}, where entry is the table word selected by in_addr[31:20].
- R2: With mode_wide=1 during the input cycle, out_addr equals {entry[43:0], in_addr[19:0]}.
- R3: A configuration write with cfg_addr[0]=0 loads entry[31:0] from cfg_wdata[31:0]. With cfg_addr[0]=1 it loads entry[43:32] from cfg_wdata[11:0], and cfg_wdata[31:12] is ignored. cfg_addr[12:1] is the entry index. The other part of the entry keeps its value.
- R4: out_valid, out_addr and out_payload reflect the input sampled on the previous rising clock edge, with no other latency.
- R5: out_valid is 0 while rst_n is low. After reset, out_valid equals the in_valid sampled one clock earlier.
- R6: out_payload equals the in_payload sampled with the transaction, bit for bit.
- R7: When a configuration write and a lookup address the same entry in the same cycle, the lookup returns the entry's previous contents. The next lookup of that entry returns the new contents.
- R8: The mode is captured with each transaction, so consecutive transactions may alternate between narrow and wide results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wide | input | 1 | 1 selects a 64-bit result, 0 selects a 32-bit result |
| in_valid | input | 1 | Input transaction valid |
| in_addr | input | 32 | Incoming destination address |
| in_payload | input | 72 | Rest of the transaction, passed through |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 13 | {entry index, word select} |
| cfg_wdata | input | 32 | Configuration write data |
| out_valid | output | 1 | Output transaction valid |
| out_addr | output | 64 | Translated address |
| out_payload | output | 72 | Payload delayed by one clock |

## Verification
A configuration write and a lookup can fall in the same cycle. When both hit the same entry, the result depends on read ordering. The bench provokes this by driving a low-word write and a lookup of that same index on one clock edge. It then expects the pre-write value on that result and the new value on an immediate second lookup. Both expectations come from a model table that is updated only after each comparison.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int unsigned RM_ADDR_W = 32;
  localparam int unsigned RM_LOW_W  = 20;
  localparam int unsigned RM_WIDE_W = 64;
  localparam int unsigned RM_CFG_W  = 32;
  localparam int unsigned RM_PAY_W  = 72;

  function automatic int unsigned words_needed(int unsigned ent_w, int unsigned cfg_w);
    return (ent_w + cfg_w - 1) / cfg_w;
  endfunction

  function automatic int unsigned sel_bits(int unsigned nwords);
    return (nwords > 1) ? $clog2(nwords) : 1;
  endfunction
endpackage

// File: rtl/remap_bank.sv
module remap_bank #(
  parameter int unsigned DEPTH_W = 12,
  parameter int unsigned W       = 32
) (
  input  logic               clk,
  input  logic               we,
  input  logic [DEPTH_W-1:0] waddr,
  input  logic [W-1:0]       wdata,
  input  logic               re,
  input  logic [DEPTH_W-1:0] raddr,
  output logic [W-1:0]       rdata
);
  localparam int unsigned DEPTH = 1 << DEPTH_W;

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_q;

  // Read and write share one edge; the read sees the value held before it.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/remap_table.sv
module remap_table
  import remap_pkg::*;
#(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned ENT_W = 44,
  parameter int unsigned CFG_W = 32,
  localparam int unsigned NWORDS = words_needed(ENT_W, CFG_W),
  localparam int unsigned SEL_W  = sel_bits(NWORDS),
  localparam int unsigned CA_W   = IDX_W + SEL_W
) (
  input  logic             clk,
  input  logic             cfg_we,
  input  logic [CA_W-1:0]  cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] entry
);
  logic [IDX_W-1:0] wr_idx;
  logic [SEL_W-1:0] wr_sel;

  assign wr_idx = cfg_addr[CA_W-1:SEL_W];
  assign wr_sel = cfg_addr[SEL_W-1:0];

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    localparam int unsigned LO = k * CFG_W;
    localparam int unsigned BW = (k == NWORDS - 1) ? (ENT_W - LO) : CFG_W;
    logic bank_we;
    assign bank_we = cfg_we && (wr_sel == SEL_W'(k));
    remap_bank #(.DEPTH_W(IDX_W), .W(BW)) u_bank (
      .clk  (clk),
      .we   (bank_we),
      .waddr(wr_idx),
      .wdata(cfg_wdata[BW-1:0]),
      .re   (rd_en),
      .raddr(rd_idx),
      .rdata(entry[LO +: BW])
    );
    if (BW < CFG_W) begin : g_spare
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^cfg_wdata[CFG_W-1:BW];
    end
  end
endmodule

// File: rtl/remap_out_stage.sv
module remap_out_stage #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LOW_W  = 20,
  parameter int unsigned WIDE_W = 64,
  parameter int unsigned PAY_W  = 72,
  localparam int unsigned NAR_W = ADDR_W - LOW_W,
  localparam int unsigned ENT_W = WIDE_W - LOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_wide,
  input  logic [LOW_W-1:0]  in_low,
  input  logic [PAY_W-1:0]  in_payload,
  input  logic [ENT_W-1:0]  entry,
  output logic              out_valid,
  output logic [WIDE_W-1:0] out_addr,
  output logic [PAY_W-1:0]  out_payload
);
  logic             valid_d, valid_q;
  logic             wide_d, wide_q;
  logic [LOW_W-1:0] low_d, low_q;
  logic [PAY_W-1:0] pay_d, pay_q;

  always_comb begin
    valid_d = in_valid;
    wide_d  = wide_q;
    low_d   = low_q;
    pay_d   = pay_q;
    if (in_valid) begin
      wide_d = in_wide;
      low_d  = in_low;
      pay_d  = in_payload;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    wide_q <= wide_d;
    low_q  <= low_d;
    pay_q  <= pay_d;
  end

  always_comb begin
    if (wide_q) out_addr = {entry, low_q};
    else        out_addr = {{(WIDE_W - ADDR_W){1'b0}}, entry[NAR_W-1:0], low_q};
  end

  assign out_valid   = valid_q;
  assign out_payload = pay_q;

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r5_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r4_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr[LOW_W-1:0] == $past(in_low));
  a_r6_payload_kept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_payload == $past(in_payload));
  a_r1_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(in_wide)) |-> out_addr[WIDE_W-1:ADDR_W] == '0);
endmodule

// File: rtl/remap_lut.sv
module remap_lut
  import remap_pkg::*;
#(
  parameter int unsigned ADDR_W = RM_ADDR_W,
  parameter int unsigned LOW_W  = RM_LOW_W,
  parameter int unsigned WIDE_W = RM_WIDE_W,
  parameter int unsigned CFG_W  = RM_CFG_W,
  parameter int unsigned PAY_W  = RM_PAY_W,
  localparam int unsigned IDX_W = ADDR_W - LOW_W,
  localparam int unsigned ENT_W = WIDE_W - LOW_W,
  localparam int unsigned CA_W  = IDX_W + sel_bits(words_needed(ENT_W, CFG_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [PAY_W-1:0]  in_payload,
  input  logic              cfg_we,
  input  logic [CA_W-1:0]   cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              out_valid,
  output logic [WIDE_W-1:0] out_addr,
  output logic [PAY_W-1:0]  out_payload
);
  logic [ENT_W-1:0] entry;

  remap_table #(.IDX_W(IDX_W), .ENT_W(ENT_W), .CFG_W(CFG_W)) u_table (
    .clk      (clk),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .rd_en    (in_valid),
    .rd_idx   (in_addr[ADDR_W-1:LOW_W]),
    .entry    (entry)
  );

  remap_out_stage #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .WIDE_W(WIDE_W), .PAY_W(PAY_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_wide    (mode_wide),
    .in_low     (in_addr[LOW_W-1:0]),
    .in_payload (in_payload),
    .entry      (entry),
    .out_valid  (out_valid),
    .out_addr   (out_addr),
    .out_payload(out_payload)
  );

  a_r3_cfg_addr_known: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !$isunknown(cfg_addr));
endmodule

// File: tb/test_remap_lut.sv
module test_remap_lut;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_wide;
  logic        in_valid;
  logic [31:0] in_addr;
  logic [71:0] in_payload;
  logic        cfg_we;
  logic [12:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic        out_valid;
  logic [63:0] out_addr;
  logic [71:0] out_payload;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [31:0] m_lo [4096];
  logic [11:0] m_hi [4096];

  always #5 clk = ~clk;

  remap_lut i_remap_lut (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .in_valid(in_valid),
    .in_addr(in_addr), .in_payload(in_payload), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
    .out_addr(out_addr), .out_payload(out_payload)
  );

  // Called at a falling edge; one rising edge passes, then outputs are compared.
  task automatic apply(input string req, input bit v, input logic [31:0] a,
                       input logic [71:0] p, input bit m, input bit we,
                       input logic [12:0] ca, input logic [31:0] cd);
    logic [63:0] exp_addr;
    logic [11:0] ix;
    ix = a[31:20];
    if (m) exp_addr = {m_hi[ix], m_lo[ix], a[19:0]};
    else   exp_addr = {32'b0, m_lo[ix][11:0], a[19:0]};
    in_valid = v; in_addr = a; in_payload = p; mode_wide = m;
    cfg_we = we; cfg_addr = ca; cfg_wdata = cd;
    @(negedge clk);
    vectors++;
    if (out_valid !== v ||
        (v && (out_addr !== exp_addr || out_payload !== p))) begin
      errors++;
      $display("FAIL %s: valid=%0b addr=%h pay=%h expected valid=%0b addr=%h pay=%h",
               req, out_valid, out_addr, out_payload, v, exp_addr, p);
    end
    if (we) begin
      if (ca[0]) m_hi[ca[12:1]] = cd[11:0];
      else       m_lo[ca[12:1]] = cd;
    end
  endtask

  function automatic logic [31:0] lo_pat(int i);
    return 32'(i) * 32'h9E3779B1 + 32'h01234567;
  endfunction

  function automatic logic [71:0] pay_pat(int i, int pass);
    return {8'(pass), 32'(i) * 32'd3, ~32'(i)};
  endfunction

  initial begin
    int cycles = 0;
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: valid=%0b expected the run to complete", out_valid);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; in_addr = '0; in_payload = '0;
    mode_wide = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R5 reset: valid=%0b expected 0", out_valid);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R3: load every entry; junk in the ignored high-word data bits
    for (int i = 0; i < 4096; i++) begin
      apply("R3", 0, '0, '0, 0, 1, {12'(i), 1'b0}, lo_pat(i));
      apply("R3", 0, '0, '0, 0, 1, {12'(i), 1'b1},
            {20'(i * 5 + 1) | 20'h80000, 12'(i) ^ 12'hA5C});
    end
    apply("R5", 0, '0, '0, 0, 0, '0, '0);

    // R1: narrow sweep of all indices; R2: wide sweep; R4/R6 on every vector
    for (int pass = 0; pass < 3; pass++) begin
      for (int i = 0; i < 4096; i++) begin
        bit m;
        m = (pass == 2) ? i[0] : (pass == 1);
        apply(pass == 0 ? "R1" : (pass == 1 ? "R2" : "R8"), 1,
              {12'(i), 20'(i * 37 + pass * 1001)}, pay_pat(i, pass), m, 0, '0, '0);
      end
      apply("R5", 0, '0, '0, 0, 0, '0, '0);
    end

    // R3 partial updates: low word of 5 leaves high intact, and vice versa on 6
    apply("R3", 0, '0, '0, 0, 1, {12'd5, 1'b0}, 32'hCAFE_F00D);
    apply("R3", 1, {12'd5, 20'h00001}, pay_pat(5, 9), 1, 0, '0, '0);
    apply("R3", 0, '0, '0, 0, 1, {12'd6, 1'b1}, 32'hFFFF_F3C1);
    apply("R3", 1, {12'd6, 20'h00002}, pay_pat(6, 9), 1, 0, '0, '0);

    // R7: write and lookup of entry 9 on the same edge, then lookup again
    apply("R7", 1, {12'd9, 20'hABCDE}, pay_pat(9, 7), 1, 1, {12'd9, 1'b0}, 32'h1357_9BDF);
    apply("R7", 1, {12'd9, 20'hABCDE}, pay_pat(9, 8), 1, 0, '0, '0);
    apply("R7", 1, {12'd4095, 20'hFFFFF}, pay_pat(4095, 8), 0, 1, {12'd4095, 1'b1}, 32'h0000_0777);
    apply("R7", 1, {12'd4095, 20'hFFFFF}, pay_pat(4095, 8), 1, 0, '0, '0);

    // R5: valid/idle alternation
    for (int i = 0; i < 8; i++)
      apply("R5", i[0], {12'(i), 20'(i)}, pay_pat(i, 4), 0, 0, '0, '0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule